// File: doc/BRIEF.md
# Dual-output programmable reference divider

This block divides a single reference clock by a programmable ratio and turns the divided waveform into comparison strobes for two phase-locked loops, A and B. One count chain serves both loops. A select input either gives both loops the same comparison rate, or passes the B strobe through an extra divide-by-two so that loop B compares at half the rate of loop A. Loop A is strobed on the rising transition of the divided waveform and loop B on the falling transition. The two strobes therefore always fall in different cycles, and the two charge pumps never switch at the same moment.

Each loop has its own enable. While both loops are off, the divider is held cleared and silent. When either loop comes back, the block issues a one-cycle restart pulse so that the main dividers of the loops can clear in the same cycle. It then suppresses both strobes for one full period, so that the first comparison edges that reach the detectors are in phase. The ratio and the select are sampled at the terminal count only, so a period is never cut short while it is running.

Top module: `dual_refdiv`

## Requirements
- R1: While `rst` is high, `strobe_a_o`, `strobe_b_o`, `div_o` and `restart_o` are all 0. On the first cycle after `rst` falls with either enable high, `restart_o` is 1.
- R2: A ratio input below 8 is treated as 8, so the strobe period is 8 cycles.
- R3: A change of `ratio_i` or `half_b_i` takes effect only at the next terminal count. The period that is running finishes at the old ratio.
- R4: With an effective ratio R, `strobe_a_o` is a one-cycle pulse every R cycles. Within each period, `div_o` is high for floor(R/2) cycles, starting in the cycle of the A strobe.
- R5: With `half_b_i` = 0, `strobe_b_o` is a one-cycle pulse every R cycles, floor(R/2) cycles after each A strobe.
- R6: With `half_b_i` = 1, `strobe_b_o` fires every 2R cycles. It fires on every second falling transition, beginning with the falling transition of the first full period after a restart.
- R7: `strobe_a_o` and `strobe_b_o` are never high in the same cycle.
- R8: A loop whose enable is 0 gets no strobes. While at least one enable stays high, the count keeps running, and switching which loop is on produces no restart.
- R9: While both enables are 0, the strobes and `div_o` are 0 and the count is held at zero. Call the cycle in which an enable first rises cycle 0: `restart_o` pulses for that one cycle, and the first A strobe comes at cycle R.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_i | input | 12 | Division ratio R (values below 8 act as 8) |
| half_b_i | input | 1 | 1 = loop B at half the rate of loop A |
| en_a_i | input | 1 | Loop A enable |
| en_b_i | input | 1 | Loop B enable |
| strobe_a_o | output | 1 | Loop A comparison strobe (rising transition) |
| strobe_b_o | output | 1 | Loop B comparison strobe (falling transition) |
| div_o | output | 1 | Divided waveform |
| restart_o | output | 1 | One-cycle pulse telling the main dividers to clear |

## Verification
A count that fails to clear on wake-up shows up within the first period, because the A strobe arrives earlier than R cycles after the restart pulse. A ratio or select that is sampled at the wrong moment lengthens or shortens the very next interval between A strobes. A halving flop that starts in the wrong state moves the first B strobe by a whole period R, so the offset between A and B is wrong from the first B strobe onward. Each wake-up is measured over four periods, so every one of these faults reaches the ports within at most 4R cycles.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    localparam int RATIO_W   = 12;
    localparam int MIN_RATIO = 8;

    typedef logic [RATIO_W-1:0] ratio_t;

    // Configuration held for one whole period
    typedef struct packed {
        ratio_t ratio;
        logic   half_b;
    } cfg_t;

    // Transition events of the divided waveform
    typedef struct packed {
        logic rise;
        logic fall;
    } evt_t;

    function automatic ratio_t clamp_ratio(input ratio_t r);
        return (r < ratio_t'(MIN_RATIO)) ? ratio_t'(MIN_RATIO) : r;
    endfunction

    function automatic cfg_t make_cfg(input ratio_t r, input logic hb);
        cfg_t c;
        c.ratio  = clamp_ratio(r);
        c.half_b = hb;
        return c;
    endfunction

endpackage

// File: rtl/refdiv_wake.sv
module refdiv_wake (
    input  logic clk,
    input  logic rst,
    input  logic en_a_i,
    input  logic en_b_i,
    output logic hold_o,
    output logic restart_o
);
    logic awake;
    logic awake_q;

    assign awake = en_a_i | en_b_i;

    always_ff @(posedge clk) begin
        if (rst) awake_q <= 1'b0;
        else     awake_q <= awake;
    end

    assign hold_o    = ~awake;
    assign restart_o = awake & ~awake_q & ~rst;

    // R9: wake pulse lasts exactly one cycle
    a_r9_restart_single: assert property (@(posedge clk) disable iff (rst)
        restart_o |=> !restart_o);

endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter
    import refdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   hold_i,
    input  ratio_t ratio_i,
    input  logic   half_b_i,
    output ratio_t cnt_o,
    output logic   half_b_o,
    output evt_t   evt_o,
    output logic   armed_o,
    output logic   div_o
);
    cfg_t   cfg;
    ratio_t cnt;
    ratio_t half;
    logic   term;
    logic   armed;
    logic   active;

    assign half   = cfg.ratio >> 1;
    assign term   = (cnt == cfg.ratio - ratio_t'(1));
    assign active = ~hold_i & ~rst;

    always_ff @(posedge clk) begin
        if (rst || hold_i) begin
            cnt   <= '0;
            cfg   <= make_cfg(ratio_i, half_b_i);
            armed <= 1'b0;
        end else if (term) begin
            cnt   <= '0;
            cfg   <= make_cfg(ratio_i, half_b_i);
            armed <= 1'b1;
        end else begin
            cnt   <= cnt + ratio_t'(1);
        end
    end

    assign evt_o.rise = active & (cnt == '0);
    assign evt_o.fall = active & (cnt == half);
    assign div_o      = active & (cnt < half);
    assign armed_o    = armed;
    assign cnt_o      = cnt;
    assign half_b_o   = cfg.half_b;

    // R2: the held ratio never drops below the floor
    a_r2_ratio_floor: assert property (@(posedge clk) disable iff (rst)
        cfg.ratio >= ratio_t'(MIN_RATIO));

    // R4: count stays inside the period
    a_r4_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt < cfg.ratio);

    // R3: configuration only moves at a terminal count or while held
    a_r3_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        (!hold_i && !term) |=> $stable(cfg));

endmodule

// File: rtl/refdiv_halver.sv
module refdiv_halver (
    input  logic clk,
    input  logic rst,
    input  logic hold_i,
    input  logic fall_i,
    input  logic half_b_i,
    output logic pass_b_o
);
    logic tgl;

    always_ff @(posedge clk) begin
        if (rst || hold_i) tgl <= 1'b0;
        else if (fall_i)   tgl <= ~tgl;
    end

    assign pass_b_o = ~half_b_i | tgl;

    // R6: in halving mode, a passed falling event is followed by a blocked one
    a_r6_half_alternate: assert property (@(posedge clk) disable iff (rst || hold_i)
        (fall_i && half_b_i && tgl) |=> !tgl);

endmodule

// File: rtl/dual_refdiv.sv
module dual_refdiv
    import refdiv_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [RATIO_W-1:0]  ratio_i,
    input  logic                half_b_i,
    input  logic                en_a_i,
    input  logic                en_b_i,
    output logic                strobe_a_o,
    output logic                strobe_b_o,
    output logic                div_o,
    output logic                restart_o
);
    logic   hold;
    logic   restart;
    ratio_t cnt;
    logic   half_b;
    evt_t   evt;
    logic   armed;
    logic   pass_b;

    refdiv_wake u_wake (
        .clk       (clk),
        .rst       (rst),
        .en_a_i    (en_a_i),
        .en_b_i    (en_b_i),
        .hold_o    (hold),
        .restart_o (restart)
    );

    refdiv_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .hold_i   (hold),
        .ratio_i  (ratio_i),
        .half_b_i (half_b_i),
        .cnt_o    (cnt),
        .half_b_o (half_b),
        .evt_o    (evt),
        .armed_o  (armed),
        .div_o    (div_o)
    );

    refdiv_halver u_half (
        .clk      (clk),
        .rst      (rst),
        .hold_i   (hold),
        .fall_i   (evt.fall),
        .half_b_i (half_b),
        .pass_b_o (pass_b)
    );

    assign strobe_a_o = armed & evt.rise & en_a_i;
    assign strobe_b_o = armed & evt.fall & pass_b & en_b_i;
    assign restart_o  = restart;

    // R7: the two strobes never share a cycle
    a_r7_no_coincide: assert property (@(posedge clk) disable iff (rst)
        !(strobe_a_o && strobe_b_o));

    // R9: on wake the count starts from zero and both strobes are quiet
    a_r9_wake_cleared: assert property (@(posedge clk) disable iff (rst)
        restart_o |-> (cnt == '0) && !strobe_a_o && !strobe_b_o);

    // R8: a disabled loop receives nothing
    a_r8_gate_a: assert property (@(posedge clk) disable iff (rst)
        !en_a_i |-> !strobe_a_o);
    a_r8_gate_b: assert property (@(posedge clk) disable iff (rst)
        !en_b_i |-> !strobe_b_o);

endmodule

// File: tb/dual_refdiv_tb.sv
`timescale 1ns/1ps
module dual_refdiv_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] ratio_i = 12'd10;
    logic        half_b_i = 1'b0;
    logic        en_a_i = 1'b0;
    logic        en_b_i = 1'b0;
    logic        strobe_a_o, strobe_b_o, div_o, restart_o;

    int nvec = 0;
    int nbad = 0;

    typedef struct packed {
        logic [11:0] ratio;
        logic        sel;
        logic [11:0] eff;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{12'd8,    1'b0, 12'd8},
        '{12'd9,    1'b1, 12'd9},
        '{12'd13,   1'b0, 12'd13},
        '{12'd100,  1'b1, 12'd100},
        '{12'd3,    1'b0, 12'd8},
        '{12'd0,    1'b1, 12'd8},
        '{12'd4095, 1'b0, 12'd4095},
        '{12'd21,   1'b1, 12'd21}
    };

    always #2.5 clk = ~clk;

    dual_refdiv u_dut (
        .clk        (clk),
        .rst        (rst),
        .ratio_i    (ratio_i),
        .half_b_i   (half_b_i),
        .en_a_i     (en_a_i),
        .en_b_i     (en_b_i),
        .strobe_a_o (strobe_a_o),
        .strobe_b_o (strobe_b_o),
        .div_o      (div_o),
        .restart_o  (restart_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic sleep_cfg(input logic [11:0] r, input logic s);
        @(negedge clk);
        en_a_i = 1'b0; en_b_i = 1'b0;
        ratio_i = r; half_b_i = s;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v);
        int half, a1, a2, b1, b2, coinc, dh, rs;
        string tp;
        half = int'(v.eff) / 2;
        a1 = -1; a2 = -1; b1 = -1; b2 = -1; coinc = 0; dh = 0; rs = 0;
        tp = (v.ratio < 12'd8) ? "R2 period" : "R4 period";
        sleep_cfg(v.ratio, v.sel);
        en_a_i = 1'b1; en_b_i = 1'b1;
        #1;
        chk("R9 wake pulse", int'(restart_o), 1);
        for (int i = 1; i <= 4 * int'(v.eff) + 4; i++) begin
            @(negedge clk);
            if (strobe_a_o && strobe_b_o) coinc++;
            if (restart_o) rs++;
            if (strobe_a_o) begin
                if (a1 < 0) a1 = i; else if (a2 < 0) a2 = i;
            end
            if (strobe_b_o) begin
                if (b1 < 0) b1 = i; else if (b2 < 0) b2 = i;
            end
            if (i >= int'(v.eff) && i < 2 * int'(v.eff) && div_o) dh++;
        end
        chk("R9 first A after wake", a1, int'(v.eff));
        chk(tp, a2 - a1, int'(v.eff));
        chk("R5 A-to-B offset", b1 - a1, half);
        chk(v.sel ? "R6 B period" : "R5 B period", b2 - b1,
            v.sel ? 2 * int'(v.eff) : int'(v.eff));
        chk("R7 coincidence", coinc, 0);
        chk("R4 div high count", dh, half);
        chk("R9 extra restart", rs, 0);
    endtask

    initial begin
        #950000;
        nbad++;
        $display("FAIL R1 watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        int bad, n, t1, t2, t3, ca, cb, fb;
        // R1: reset state with an enable high
        rst = 1'b1; ratio_i = 12'd10; en_a_i = 1'b1; en_b_i = 1'b1;
        bad = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (strobe_a_o || strobe_b_o || div_o || restart_o) bad++;
        end
        chk("R1 outputs low in reset", bad, 0);
        rst = 1'b0;
        #1;
        chk("R1 restart after reset", int'(restart_o), 1);
        t1 = -1;
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk);
            if (strobe_a_o && t1 < 0) t1 = i;
        end
        chk("R1 first A after reset", t1, 10);

        // Table walk
        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R3: ratio change mid-period
        sleep_cfg(12'd10, 1'b0);
        en_a_i = 1'b1; en_b_i = 1'b1;
        t1 = -1; t2 = -1; t3 = -1;
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            if (strobe_a_o) begin
                if (t1 < 0) t1 = i; else if (t2 < 0) t2 = i; else if (t3 < 0) t3 = i;
            end
            if (i == 3) ratio_i = 12'd20;
        end
        chk("R3 old ratio finishes", t1, 10);
        chk("R3 new ratio used", t2 - t1, 20);
        chk("R3 new ratio steady", t3 - t2, 20);

        // R8: one loop on, then swap
        sleep_cfg(12'd12, 1'b0);
        en_a_i = 1'b1;
        ca = 0; cb = 0;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (strobe_a_o) ca++;
            if (strobe_b_o) cb++;
        end
        chk("R8 B silent when off", cb, 0);
        chk("R8 A runs alone", ca, 3);
        en_a_i = 1'b0; en_b_i = 1'b1;
        #1;
        chk("R8 no restart on swap", int'(restart_o), 0);
        ca = 0; fb = -1;
        for (int i = 41; i <= 60; i++) begin
            @(negedge clk);
            if (strobe_a_o) ca++;
            if (strobe_b_o && fb < 0) fb = i;
        end
        chk("R8 A silent when off", ca, 0);
        chk("R8 B keeps count phase", fb, 42);

        // R9: both off holds everything quiet
        @(negedge clk);
        en_a_i = 1'b0; en_b_i = 1'b0;
        n = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (strobe_a_o || strobe_b_o || div_o || restart_o) n++;
        end
        chk("R9 quiet while asleep", n, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule